// File: doc/BRIEF.md
# Tagged-Instruction Execute Unit

A single-cycle execute stage that takes one 16-bit instruction per clock from an input port, qualified by a valid strobe, and applies it at once to a 32-entry register file and a 10-bit program counter. The instruction word carries a one- or two-level tag. It selects one of three operations: a three-register add, a jump relative to the current program counter, or an absolute jump guarded by a register test.

Register zero reads as zero at all times, so an add that names it as destination has no effect. The conditional jump tests one of the four lowest registers, chosen by a 2-bit field. A debug port reads any register combinationally and can also write a register. Without that write path the register file could never hold anything but zero, because reset clears it and the only other writer is the add.

Top module: `tagged_exec_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0 and every register reads 0 through the debug port.
- R2: When `instr_i[15]`=0 the word is an add with source indices `[14:10]` and `[9:5]` and destination `[4:0]`. On a valid cycle the destination takes the 16-bit wrapped sum of the two sources, and `pc_o` advances by one, wrapping at 10 bits.
- R3: An add whose destination index is 0 leaves every register unchanged but still advances `pc_o` by one. Register 0 always reads 0.
- R4: When `instr_i[15:14]`=2'b10 the word is a relative jump. On a valid cycle `pc_o` becomes `pc_o + instr_i[9:0]` modulo 1024, and no register changes.
- R5: When `instr_i[15:14]`=2'b11 the word is a conditional jump that tests register `instr_i[11:10]`. On a valid cycle where that register is nonzero, `pc_o` loads `instr_i[9:0]`.
- R6: A conditional jump whose tested register is zero advances `pc_o` by one. Condition field 0 therefore never jumps.
- R7: With `instr_valid_i` low, `pc_o` holds and no register changes, whatever `instr_i` carries.
- R8: `dbg_rdata_o` shows register `dbg_addr_i` in the same cycle. With `dbg_we_i` high, that register takes `dbg_wdata_i` at the clock edge, except register 0. An add that writes the same register in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Tagged instruction word |
| instr_valid_i | input | 1 | Instruction strobe; high executes `instr_i` |
| pc_o | output | 10 | Program counter |
| dbg_addr_i | input | 5 | Debug register index |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 16 | Debug write data |
| dbg_rdata_o | output | 16 | Debug read data |

## Verification
The bench aims at the places where a decoder is easily wrong. The first is an add to register zero: a unit that forgets the discard makes register zero read back as the sum. The second is a relative jump that crosses 1023: if the adder is too wide or sign-extends, `pc_o` lands off the wrapped address. The third is a conditional jump on field zero and on a register set to zero, where a swapped condition polarity or the wrong tag bit jumps when it should step by one. Idle cycles carry live instruction patterns, and a unit that ignores the strobe moves `pc_o` or corrupts a register that is checked afterwards.

// File: rtl/tagged_exec_pkg.sv
package tagged_exec_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned PC_W    = 10;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned CC_W    = 2;
  localparam int unsigned NUM_REGS = 1 << REG_AW;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_JREL = 2'd1,
    OP_JABS = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [REG_AW-1:0] rd;
    logic [CC_W-1:0]   cc;
    logic [PC_W-1:0]   imm;
  } dec_instr_t;
endpackage

// File: rtl/tagged_exec_decode.sv
module tagged_exec_decode
  import tagged_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_instr_t         dec_o
);
  always_comb begin
    dec_o.rs1 = instr_i[14:10];
    dec_o.rs2 = instr_i[9:5];
    dec_o.rd  = instr_i[4:0];
    dec_o.cc  = instr_i[11:10];
    dec_o.imm = instr_i[PC_W-1:0];
    // outer tag bit 15, inner tag bit 14 (jumps only)
    priority casez (instr_i[15:14])
      2'b0?:   dec_o.kind = OP_ADD;
      2'b10:   dec_o.kind = OP_JREL;
      default: dec_o.kind = OP_JABS;
    endcase
  end
endmodule

// File: rtl/tagged_exec_regfile.sv
module tagged_exec_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // execute write (wins)
  input  logic              ex_we_i,
  input  logic [AW-1:0]     ex_waddr_i,
  input  logic [DATA_W-1:0] ex_wdata_i,
  // debug write
  input  logic              dbg_we_i,
  input  logic [AW-1:0]     dbg_addr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  // reads
  input  logic [AW-1:0]     ra_addr_i,
  input  logic [AW-1:0]     rb_addr_i,
  input  logic [AW-1:0]     rc_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [DATA_W-1:0] rb_data_o,
  output logic [DATA_W-1:0] rc_data_o,
  output logic [DATA_W-1:0] dbg_rdata_o
);
  logic [DATA_W-1:0] regs_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs_q[i] <= '0;
        end else if (ex_we_i && ex_waddr_i == AW'(i)) begin
          regs_q[i] <= ex_wdata_i;
        end else if (dbg_we_i && dbg_addr_i == AW'(i)) begin
          regs_q[i] <= dbg_wdata_i;
        end
      end
    end
  end

  assign ra_data_o   = regs_q[ra_addr_i];
  assign rb_data_o   = regs_q[rb_addr_i];
  assign rc_data_o   = regs_q[rc_addr_i];
  assign dbg_rdata_o = regs_q[dbg_addr_i];
endmodule

// File: rtl/tagged_exec_pc.sv
module tagged_exec_pc
  import tagged_exec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  op_kind_e        kind_i,
  input  logic [PC_W-1:0] imm_i,
  input  logic            cond_nz_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q, pc_d, pc_inc;

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    unique case (kind_i)
      OP_JREL: pc_d = pc_q + imm_i;
      OP_JABS: pc_d = cond_nz_i ? imm_i : pc_inc;
      default: pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (valid_i) pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/tagged_exec_unit.sv
module tagged_exec_unit
  import tagged_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               instr_valid_i,
  output logic [PC_W-1:0]    pc_o,
  input  logic [REG_AW-1:0]  dbg_addr_i,
  input  logic               dbg_we_i,
  input  logic [DATA_W-1:0]  dbg_wdata_i,
  output logic [DATA_W-1:0]  dbg_rdata_o
);
  dec_instr_t        dec;
  logic [DATA_W-1:0] src_a, src_b, cond_val;
  logic              add_we;

  tagged_exec_decode i_decode (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  // add to register 0 is dropped
  assign add_we = instr_valid_i && dec.kind == OP_ADD && dec.rd != '0;

  tagged_exec_regfile #(
    .DATA_W (DATA_W),
    .DEPTH  (NUM_REGS)
  ) i_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ex_we_i     (add_we),
    .ex_waddr_i  (dec.rd),
    .ex_wdata_i  (src_a + src_b),
    .dbg_we_i    (dbg_we_i),
    .dbg_addr_i  (dbg_addr_i),
    .dbg_wdata_i (dbg_wdata_i),
    .ra_addr_i   (dec.rs1),
    .rb_addr_i   (dec.rs2),
    .rc_addr_i   (REG_AW'(dec.cc)),
    .ra_data_o   (src_a),
    .rb_data_o   (src_b),
    .rc_data_o   (cond_val),
    .dbg_rdata_o (dbg_rdata_o)
  );

  tagged_exec_pc i_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (instr_valid_i),
    .kind_i    (dec.kind),
    .imm_i     (dec.imm),
    .cond_nz_i (cond_val != '0),
    .pc_o      (pc_o)
  );
endmodule

// File: rtl/tagged_exec_unit_chk.sv
module tagged_exec_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] instr_i,
  input logic        instr_valid_i,
  input logic [9:0]  pc_o,
  input logic [4:0]  dbg_addr_i,
  input logic [15:0] dbg_rdata_o
);
  AST_RESET_PC: assert property (@(posedge clk_i) !rst_ni |-> pc_o == 10'd0); // R1

  AST_IDLE_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> $stable(pc_o)); // R7

  AST_ADD_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !instr_i[15] |=> pc_o == $past(pc_o) + 10'd1); // R2

  AST_REL_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[15:14] == 2'b10 |=> pc_o == $past(pc_o) + $past(instr_i[9:0])); // R4

  AST_COND_JUMP_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[15:14] == 2'b11
    |=> (pc_o == $past(instr_i[9:0]) || pc_o == $past(pc_o) + 10'd1)); // R5

  AST_CC0_NEVER_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[15:14] == 2'b11 && instr_i[11:10] == 2'b00
    |=> pc_o == $past(pc_o) + 10'd1); // R6

  AST_REG0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_addr_i == 5'd0 |-> dbg_rdata_o == 16'd0); // R3
endmodule

bind tagged_exec_unit tagged_exec_unit_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_i       (instr_i),
  .instr_valid_i (instr_valid_i),
  .pc_o          (pc_o),
  .dbg_addr_i    (dbg_addr_i),
  .dbg_rdata_o   (dbg_rdata_o)
);

// File: tb/test_tagged_exec_unit.sv
`timescale 1ns/1ps
module test_tagged_exec_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic        instr_valid_i = 1'b0;
  logic [9:0]  pc_o;
  logic [4:0]  dbg_addr_i = '0;
  logic        dbg_we_i = 1'b0;
  logic [15:0] dbg_wdata_i = '0;
  logic [15:0] dbg_rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_reg [32];
  logic [9:0]  m_pc;

  always #10 clk = ~clk; // 50 MHz

  tagged_exec_unit i_tagged_exec_unit (
    .clk_i (clk), .rst_ni (rst_ni), .instr_i (instr_i), .instr_valid_i (instr_valid_i),
    .pc_o (pc_o), .dbg_addr_i (dbg_addr_i), .dbg_we_i (dbg_we_i),
    .dbg_wdata_i (dbg_wdata_i), .dbg_rdata_o (dbg_rdata_o)
  );

  function automatic logic [15:0] enc_add(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    return {1'b0, a, b, d};
  endfunction
  function automatic logic [15:0] enc_rel(input logic [9:0] off);
    return {2'b10, 4'b0000, off};
  endfunction
  function automatic logic [15:0] enc_abs(input logic [1:0] cc, input logic [9:0] tgt);
    return {2'b11, 2'b00, cc, tgt};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_exec(input logic [15:0] w);
    if (!w[15]) begin
      if (w[4:0] != 5'd0) m_reg[w[4:0]] = m_reg[w[14:10]] + m_reg[w[9:5]];
      m_pc = m_pc + 10'd1;
    end else if (!w[14]) begin
      m_pc = m_pc + w[9:0];
    end else if (m_reg[{3'b000, w[11:10]}] != 16'd0) begin
      m_pc = w[9:0];
    end else begin
      m_pc = m_pc + 10'd1;
    end
  endtask

  task automatic read_reg(input logic [4:0] a, input string req);
    dbg_addr_i = a;
    #1;
    check(dbg_rdata_o == m_reg[a], req, dbg_rdata_o, m_reg[a]);
  endtask

  // one clock: called at negedge, returns at next negedge with pc checked
  task automatic step(input logic [15:0] w, input bit v, input string req);
    instr_i = w;
    instr_valid_i = v;
    if (v) model_exec(w);
    @(posedge clk);
    @(negedge clk);
    instr_valid_i = 1'b0;
    check(pc_o == m_pc, req, pc_o, m_pc);
  endtask

  task automatic dbg_write(input logic [4:0] a, input logic [15:0] d);
    dbg_addr_i = a;
    dbg_wdata_i = d;
    dbg_we_i = 1'b1;
    instr_i = $urandom();
    if (a != 5'd0) m_reg[a] = d;
    @(posedge clk);
    @(negedge clk);
    dbg_we_i = 1'b0;
    check(pc_o == m_pc, "R7", pc_o, m_pc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pc_o == 10'd0, "R1", pc_o, 0);
    for (int i = 0; i < 32; i++) read_reg(5'(i), "R1");
    rst_ni = 1'b1;
    @(negedge clk);

    // R8: debug load
    for (int i = 1; i < 32; i++) dbg_write(5'(i), 16'($urandom()));
    dbg_write(5'd0, 16'hBEEF);
    read_reg(5'd0, "R8");
    for (int i = 1; i < 32; i++) read_reg(5'(i), "R8");

    // R2: add with overflow
    dbg_write(5'd5, 16'hFFF0);
    dbg_write(5'd6, 16'h0025);
    step(enc_add(5'd5, 5'd6, 5'd7), 1'b1, "R2");
    read_reg(5'd7, "R2");
    // R3: discard to r0
    step(enc_add(5'd5, 5'd6, 5'd0), 1'b1, "R3");
    read_reg(5'd0, "R3");
    read_reg(5'd7, "R3");
    // R4: relative jump wrapping past 1023
    step(enc_rel(10'd1000), 1'b1, "R4");
    step(enc_rel(10'd100), 1'b1, "R4");
    // R6: field 0 never jumps; zero register does not jump
    step(enc_abs(2'd0, 10'd333), 1'b1, "R6");
    dbg_write(5'd2, 16'd0);
    step(enc_abs(2'd2, 10'd444), 1'b1, "R6");
    // R5: nonzero register jumps
    dbg_write(5'd1, 16'h0100);
    step(enc_abs(2'd1, 10'd777), 1'b1, "R5");
    dbg_write(5'd3, 16'h8000);
    step(enc_abs(2'd3, 10'd5), 1'b1, "R5");
    // R7: idle with live patterns
    dbg_addr_i = 5'd9;
    step(enc_add(5'd1, 5'd3, 5'd9), 1'b0, "R7");
    read_reg(5'd9, "R7");
    step(enc_rel(10'd9), 1'b0, "R7");
    step(enc_abs(2'd1, 10'd9), 1'b0, "R7");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] w;
      int sel;
      sel = $urandom_range(0, 9);
      w = 16'($urandom());
      if (n % 20 == 0) begin
        dbg_write(5'($urandom_range(0, 4)), ($urandom_range(0, 3) == 0) ? 16'd0 : 16'($urandom()));
      end else if (sel < 2) begin
        step(w, 1'b0, "R7");
      end else begin
        if (sel < 6) w[15] = 1'b0;
        step(w, 1'b1, !w[15] ? (w[4:0] == 5'd0 ? "R3" : "R2") : (!w[14] ? "R4" : "R5"));
      end
      read_reg(5'($urandom_range(0, 31)), "R8");
      if (!w[15]) read_reg(w[4:0], "R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule